// File: doc/BRIEF.md
# External Bus Release Arbiter

This block sits on the local bus master's side of a shared external memory bus. It decides when an outside device may take that bus and when the local side must get it back. An outside master asks for the bus on an active-low request line. The arbiter passes that request through a two-stage synchroniser. It then waits until the local bus engine reaches a real boundary: no bus cycle in flight, no burst line fill or write-back, no test-and-set between its read and its write, and no access that is split into narrow sub-cycles still part-way through. At that point it asserts an active-low grant and turns off the local pin drivers in the same cycle.

While the bus is away, the local side may need it again, for a memory refresh or for an interrupt. The arbiter then drives an active-low request-back line, and the outside master is expected to drop its request in response. When the request goes away, the grant is removed first. The local drivers come back one clock later, so the two masters never drive the pins together. A hold output tells the local bus engine not to start new work while a release is pending or in force. An internal need that is already pending while the local side owns the bus holds back acceptance of a new outside request.

Top module: `bus_release_arb`

## Requirements
- R1: After reset, grant_n = 1, drive_en = 1, reclaim_n = 1 and cyc_hold = 0.
- R2: With the local bus idle and no lock or internal need, cyc_hold rises on the 3rd rising edge after ext_req_n falls, and grant_n falls on the 4th rising edge.
- R3: While cyc_active = 1, grant_n stays 1. Once cyc_active returns to 0, with no lock active, grant_n falls on the next rising edge.
- R4: While burst_active = 1, grant_n stays 1. Once it returns to 0, grant_n falls on the next rising edge.
- R5: While rmw_active = 1, grant_n stays 1. Once it returns to 0, grant_n falls on the next rising edge.
- R6: While split_active = 1, grant_n stays 1. Once it returns to 0, grant_n falls on the next rising edge.
- R7: drive_en is 0 in every cycle in which grant_n is 0, and it falls in the same cycle that grant_n falls.
- R8: After ext_req_n rises during a release, grant_n rises on the 3rd rising edge. drive_en rises, and cyc_hold falls, one edge later (the 4th).
- R9: If ext_req_n rises again before a boundary is reached, the arbiter returns to local ownership on the 3rd edge (cyc_hold = 0) and never asserts grant_n.
- R10: While the bus is released, refresh_pend = 1 or irq_pend = 1 drives reclaim_n to 0 on the next edge. reclaim_n then stays 0, even if the need goes away, until the edge on which drive_en returns to 1, where it becomes 1.
- R11: While the local side owns the bus and refresh_pend or irq_pend is 1, a pending outside request is not accepted (cyc_hold stays 0). Once the need clears, cyc_hold rises on the next edge and grant_n falls on the edge after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_req_n | input | 1 | Active-low bus release request from the outside master, asynchronous |
| cyc_active | input | 1 | A local bus cycle is in progress |
| burst_active | input | 1 | A burst line fill or write-back is in progress |
| rmw_active | input | 1 | A test-and-set is between its read and its write |
| split_active | input | 1 | A split narrow access still has sub-cycles to run |
| refresh_pend | input | 1 | Memory refresh is waiting for the bus |
| irq_pend | input | 1 | Interrupt processing is waiting for the bus |
| grant_n | output | 1 | Active-low bus grant to the outside master |
| drive_en | output | 1 | Enable for the local address, data and control pin drivers |
| reclaim_n | output | 1 | Active-low request for the outside master to give the bus back |
| cyc_hold | output | 1 | Tells the local bus engine to start no new cycles |

## Verification
The bench holds each kind of indivisible sequence and a plain bus cycle active across the point where the synchronised request arrives. A design that ignored any one of them would grant in the 4th cycle, on top of a locked transfer. It checks the exact edges of the hand-over in both directions. A design without the gap cycle would turn the drivers back on while the grant is still visible, and the bench would see both masters enabled. Request-back is raised while released and the need is then removed before the bus returns. A design that tracked the need level instead of latching it would drop reclaim_n early. The bench also covers an outside request withdrawn before a boundary, and a request made while an internal need is pending, where a wrong design would hand the bus away just before a refresh.

// File: rtl/busrel_pkg.sv
package busrel_pkg;

    typedef enum logic [1:0] {
        ST_OWNED         = 2'd0,
        ST_WAIT_BOUNDARY = 2'd1,
        ST_RELEASED      = 2'd2,
        ST_RECLAIM       = 2'd3
    } arb_state_e;

    // Indivisible sequences reported by the local bus engine
    typedef struct packed {
        logic burst;
        logic rmw;
        logic split;
    } lock_t;

    // Decoded pin-level view of the arbiter, active-high internally
    typedef struct packed {
        logic grant;
        logic drive;
        logic hold;
    } arb_out_t;

    function automatic logic lock_any(input lock_t l);
        return l.burst | l.rmw | l.split;
    endfunction

    function automatic arb_out_t decode_state(input arb_state_e s);
        arb_out_t o;
        o.grant = (s == ST_RELEASED);
        o.drive = (s == ST_OWNED) || (s == ST_WAIT_BOUNDARY);
        o.hold  = (s != ST_OWNED);
        return o;
    endfunction

    function automatic logic keeps_reclaim(input arb_state_e s);
        return (s == ST_RELEASED) || (s == ST_RECLAIM);
    endfunction

endpackage

// File: rtl/busrel_sync.sv
module busrel_sync #(
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= IDLE;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= IDLE;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/busrel_gate.sv
module busrel_gate
    import busrel_pkg::*;
(
    input  logic  cyc_active,
    input  lock_t locks,
    input  logic  refresh_pend,
    input  logic  irq_pend,
    output logic  boundary_ok,
    output logic  internal_need
);
    always_comb begin
        boundary_ok   = !cyc_active && !lock_any(locks);
        internal_need = refresh_pend || irq_pend;
    end
endmodule

// File: rtl/busrel_fsm.sv
module busrel_fsm
    import busrel_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       boundary_ok,
    input  logic       internal_need,
    output arb_state_e state,
    output logic       reclaim
);
    arb_state_e state_d;
    logic       reclaim_d;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_OWNED: begin
                if (req && !internal_need) state_d = ST_WAIT_BOUNDARY;
            end
            ST_WAIT_BOUNDARY: begin
                if (!req)             state_d = ST_OWNED;
                else if (boundary_ok) state_d = ST_RELEASED;
            end
            ST_RELEASED: begin
                if (!req) state_d = ST_RECLAIM;
            end
            ST_RECLAIM: begin
                state_d = ST_OWNED;
            end
            default: state_d = ST_OWNED;
        endcase
    end

    always_comb begin
        reclaim_d = (reclaim || ((state == ST_RELEASED) && internal_need))
                    && keeps_reclaim(state_d);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_OWNED;
            reclaim <= 1'b0;
        end else begin
            state   <= state_d;
            reclaim <= reclaim_d;
        end
    end
endmodule

// File: rtl/bus_release_arb.sv
module bus_release_arb
    import busrel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_req_n,
    input  logic cyc_active,
    input  logic burst_active,
    input  logic rmw_active,
    input  logic split_active,
    input  logic refresh_pend,
    input  logic irq_pend,
    output logic grant_n,
    output logic drive_en,
    output logic reclaim_n,
    output logic cyc_hold
);
    logic       req_n_sync;
    logic       boundary_ok;
    logic       internal_need;
    lock_t      locks;
    arb_state_e state;
    logic       reclaim;
    arb_out_t   outs;

    assign locks.burst = burst_active;
    assign locks.rmw   = rmw_active;
    assign locks.split = split_active;

    busrel_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ext_req_n),
        .q   (req_n_sync)
    );

    busrel_gate u_gate (
        .cyc_active    (cyc_active),
        .locks         (locks),
        .refresh_pend  (refresh_pend),
        .irq_pend      (irq_pend),
        .boundary_ok   (boundary_ok),
        .internal_need (internal_need)
    );

    busrel_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .req           (!req_n_sync),
        .boundary_ok   (boundary_ok),
        .internal_need (internal_need),
        .state         (state),
        .reclaim       (reclaim)
    );

    assign outs      = decode_state(state);
    assign grant_n   = !outs.grant;
    assign drive_en  = outs.drive;
    assign cyc_hold  = outs.hold;
    assign reclaim_n = !reclaim;
endmodule

// File: rtl/busrel_chk.sv
module busrel_chk (
    input logic clk,
    input logic rst,
    input logic cyc_active,
    input logic burst_active,
    input logic rmw_active,
    input logic split_active,
    input logic refresh_pend,
    input logic irq_pend,
    input logic grant_n,
    input logic drive_en,
    input logic reclaim_n,
    input logic cyc_hold
);
    // R3 R4 R5 R6
    grant_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(grant_n) |-> $past(!cyc_active && !burst_active && !rmw_active && !split_active));

    // R7
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !grant_n |-> !drive_en);

    // R8
    drive_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_en) |-> (grant_n && $past(grant_n)));

    // R10
    reclaim_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (!grant_n && (refresh_pend || irq_pend)) |=> !reclaim_n);

    // R10
    reclaim_only_away_chk: assert property (@(posedge clk) disable iff (rst)
        !reclaim_n |-> !drive_en);

    // R10
    reclaim_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(reclaim_n) |-> drive_en);

    // R11
    need_defers_chk: assert property (@(posedge clk) disable iff (rst)
        (drive_en && !cyc_hold && (refresh_pend || irq_pend)) |=> !cyc_hold);

    // R9
    hold_when_away_chk: assert property (@(posedge clk) disable iff (rst)
        !drive_en |-> cyc_hold);
endmodule

bind bus_release_arb busrel_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cyc_active   (cyc_active),
    .burst_active (burst_active),
    .rmw_active   (rmw_active),
    .split_active (split_active),
    .refresh_pend (refresh_pend),
    .irq_pend     (irq_pend),
    .grant_n      (grant_n),
    .drive_en     (drive_en),
    .reclaim_n    (reclaim_n),
    .cyc_hold     (cyc_hold)
);

// File: tb/sim_bus_release_arb.sv
`timescale 1ns/1ps
module sim_bus_release_arb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_req_n = 1'b1;
    logic cyc_active = 1'b0;
    logic burst_active = 1'b0;
    logic rmw_active = 1'b0;
    logic split_active = 1'b0;
    logic refresh_pend = 1'b0;
    logic irq_pend = 1'b0;
    logic grant_n, drive_en, reclaim_n, cyc_hold;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    bus_release_arb u0 (
        .clk(clk), .rst(rst), .ext_req_n(ext_req_n),
        .cyc_active(cyc_active), .burst_active(burst_active),
        .rmw_active(rmw_active), .split_active(split_active),
        .refresh_pend(refresh_pend), .irq_pend(irq_pend),
        .grant_n(grant_n), .drive_en(drive_en),
        .reclaim_n(reclaim_n), .cyc_hold(cyc_hold)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Takes the bus away on an idle bus, ends in the released state
    task automatic grab_idle();
        ext_req_n = 1'b0;
        tick(4);
    endtask

    task automatic give_back();
        ext_req_n = 1'b1;
        tick(4);
        chk("R8 back home drive_en", drive_en, 1'b1);
    endtask

    task automatic t_reset();
        chk("R1 grant_n", grant_n, 1'b1);
        chk("R1 drive_en", drive_en, 1'b1);
        chk("R1 reclaim_n", reclaim_n, 1'b1);
        chk("R1 cyc_hold", cyc_hold, 1'b0);
    endtask

    task automatic t_idle_release();
        ext_req_n = 1'b0;
        tick(2);
        chk("R2 edge2 cyc_hold", cyc_hold, 1'b0);
        tick(1);
        chk("R2 edge3 cyc_hold", cyc_hold, 1'b1);
        chk("R2 edge3 grant_n", grant_n, 1'b1);
        chk("R7 edge3 drive_en", drive_en, 1'b1);
        tick(1);
        chk("R2 edge4 grant_n", grant_n, 1'b0);
        chk("R7 edge4 drive_en", drive_en, 1'b0);
        ext_req_n = 1'b1;
        tick(2);
        chk("R8 edge2 grant_n", grant_n, 1'b0);
        tick(1);
        chk("R8 edge3 grant_n", grant_n, 1'b1);
        chk("R8 edge3 drive_en", drive_en, 1'b0);
        chk("R8 edge3 cyc_hold", cyc_hold, 1'b1);
        tick(1);
        chk("R8 edge4 drive_en", drive_en, 1'b1);
        chk("R8 edge4 cyc_hold", cyc_hold, 1'b0);
    endtask

    // which: 0 cycle, 1 burst, 2 rmw, 3 split
    task automatic t_locked(input int which, input string tag);
        case (which)
            0: cyc_active = 1'b1;
            1: burst_active = 1'b1;
            2: rmw_active = 1'b1;
            default: split_active = 1'b1;
        endcase
        ext_req_n = 1'b0;
        tick(4);
        chk({tag, " held at edge4 grant_n"}, grant_n, 1'b1);
        chk({tag, " waiting cyc_hold"}, cyc_hold, 1'b1);
        tick(6);
        chk({tag, " held later grant_n"}, grant_n, 1'b1);
        chk({tag, " held later drive_en"}, drive_en, 1'b1);
        cyc_active = 1'b0;
        burst_active = 1'b0;
        rmw_active = 1'b0;
        split_active = 1'b0;
        tick(1);
        chk({tag, " after lock grant_n"}, grant_n, 1'b0);
        give_back();
    endtask

    task automatic t_withdraw();
        burst_active = 1'b1;
        ext_req_n = 1'b0;
        tick(3);
        chk("R9 waiting cyc_hold", cyc_hold, 1'b1);
        ext_req_n = 1'b1;
        tick(2);
        chk("R9 edge2 cyc_hold", cyc_hold, 1'b1);
        tick(1);
        chk("R9 edge3 cyc_hold", cyc_hold, 1'b0);
        burst_active = 1'b0;
        tick(4);
        chk("R9 no grant", grant_n, 1'b1);
        chk("R9 drive kept", drive_en, 1'b1);
    endtask

    task automatic t_reclaim(input logic use_irq);
        grab_idle();
        chk("R10 released grant_n", grant_n, 1'b0);
        chk("R10 quiet reclaim_n", reclaim_n, 1'b1);
        if (use_irq) irq_pend = 1'b1; else refresh_pend = 1'b1;
        tick(1);
        chk("R10 raised reclaim_n", reclaim_n, 1'b0);
        irq_pend = 1'b0;
        refresh_pend = 1'b0;
        tick(3);
        chk("R10 latched reclaim_n", reclaim_n, 1'b0);
        ext_req_n = 1'b1;
        tick(3);
        chk("R10 gap reclaim_n", reclaim_n, 1'b0);
        chk("R10 gap grant_n", grant_n, 1'b1);
        tick(1);
        chk("R10 home reclaim_n", reclaim_n, 1'b1);
        chk("R10 home drive_en", drive_en, 1'b1);
    endtask

    task automatic t_need_defers();
        refresh_pend = 1'b1;
        ext_req_n = 1'b0;
        tick(8);
        chk("R11 deferred cyc_hold", cyc_hold, 1'b0);
        chk("R11 deferred grant_n", grant_n, 1'b1);
        refresh_pend = 1'b0;
        tick(1);
        chk("R11 accept cyc_hold", cyc_hold, 1'b1);
        chk("R11 accept grant_n", grant_n, 1'b1);
        tick(1);
        chk("R11 grant_n", grant_n, 1'b0);
        give_back();
    endtask

    initial begin
        #100000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_idle_release();
        t_locked(0, "R3");
        t_locked(1, "R4");
        t_locked(2, "R5");
        t_locked(3, "R6");
        t_withdraw();
        t_reclaim(1'b0);
        t_reclaim(1'b1);
        t_need_defers();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule